// File: doc/BRIEF.md
# Indirect Command/Status Bus Bridge

This bridge gives a host that only has a 64-bit register port access to a downstream bus with 32-bit addresses. The host sees a window of four 64-bit registers. It loads a 32-bit value into the data register. It then writes a command word into the control register. The bridge performs one downstream read or write. The host learns the result by polling the status register, which clears itself when read.

The downstream side is a request/acknowledge master. The request stays high until the acknowledge arrives or a fixed cycle limit runs out. Read data is packed into a field of the status word. A failed read puts all ones in that field. A write reports only completion, whether or not it succeeded. A command that asks for more than eight bytes is dropped with no trace. A command written while another is still outstanding is also ignored.

Top module: `icb_bridge`

## Requirements
- R1: The register is selected by host address bits 4:3, so every multiple of 32 bytes aliases the same four registers: 0 = control, 1 = reset, 2 = status, 3 = data.
- R2: A host write to the data register stores write-data bits 63:32. A read of it returns the stored value in bits 63:32 and zeros in bits 31:0.
- R3: Reads of control and reset return zero. Host writes to status and reset change neither the status value nor the downstream port.
- R4: A control write with no operation outstanding raises the downstream request in the next cycle. The operation is a read when command bit 48 is 1 and a write when it is 0. Bits 59:56 give the byte count and bits 31:0 the address. Address, size and direction hold steady until the request ends.
- R5: A control write whose byte count is above 8 makes no downstream request and leaves the status value unchanged.
- R6: A successful read sets status bit 11 (done). It places the downstream read data, first byte most significant, in status bits 57:26. All other bits are zero.
- R7: A read completed with the error flag set yields status bit 11 together with all ones in bits 57:26.
- R8: A completed write leaves status equal to only bit 11, with or without the error flag. The write data carries the data register value, first byte in bits 31:24.
- R9: A status read returns the current value and clears the status to zero in the same access.
- R10: A control write while an operation is outstanding is ignored.
- R11: A status read while an operation is outstanding returns zero.
- R12: If no acknowledge arrives within 256 cycles of the request rising, the request drops and the operation completes as failed.
- R13: Read data of the host port appears, with its valid strobe, in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | HOST_AW | Host byte address; bits 4:3 select the register |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data |
| host_rvalid | output | 1 | Read data valid, one cycle after a read |
| ds_req | output | 1 | Downstream request, held until acknowledge or time-out |
| ds_we | output | 1 | Downstream direction, 1 = write |
| ds_addr | output | 32 | Downstream address |
| ds_size | output | 4 | Downstream byte count |
| ds_wdata | output | 32 | Downstream write data, first byte in bits 31:24 |
| ds_ack | input | 1 | Downstream acknowledge |
| ds_rdata | input | 32 | Downstream read data, first byte in bits 31:24 |
| ds_err | input | 1 | Downstream error flag, valid with ds_ack |

## Verification
A control write shows on the request one cycle after its clock edge. A completion shows in the status value one edge after the acknowledge. A host read returns data one edge after its request, and a time-out drops the request exactly 256 edges after it rose. The bench drives inputs and samples outputs on falling edges. Each check is placed at the first falling edge after the register stage that produces the result, so every result is read in the cycle it becomes due, not at some later time.

// File: rtl/icb_pkg.sv
// Shared types and field positions of the indirect command/status bridge.
// Assumes the 64-bit command and status word layouts given in the brief.
package icb_pkg;

    typedef enum logic [1:0] {
        IDX_CTRL = 2'd0,
        IDX_RSTR = 2'd1,
        IDX_STAT = 2'd2,
        IDX_DATA = 2'd3
    } win_idx_e;

    localparam int unsigned CMD_RD_BIT    = 48;
    localparam int unsigned STAT_DONE_BIT = 11;
    localparam int unsigned STAT_RD_LSB   = 26;
    localparam int unsigned HALF_W        = 32;

    typedef struct packed {
        logic        rd;
        logic [3:0]  nbytes;
        logic [31:0] addr;
    } cmd_t;

    // Extracts the operation fields from a control-register write.
    function automatic cmd_t decode_cmd(input logic [63:0] w);
        cmd_t c;
        c.rd     = w[CMD_RD_BIT];
        c.nbytes = w[59:56];
        c.addr   = w[31:0];
        return c;
    endfunction

    // Builds the status word for a completed operation.
    function automatic logic [63:0] pack_status(input logic was_rd,
                                                input logic failed,
                                                input logic [31:0] rdat);
        logic [63:0] s;
        s = '0;
        s[STAT_DONE_BIT] = 1'b1;
        if (was_rd) begin
            s[STAT_RD_LSB +: HALF_W] = failed ? {HALF_W{1'b1}} : rdat;
        end
        return s;
    endfunction

endpackage

// File: rtl/icb_host_regs.sv
// Host-side window decode: data register, registered read mux, launch gate.
// Assumes one-cycle host strobes; index comes from address bits 4:3.
module icb_host_regs
    import icb_pkg::*;
#(
    parameter int unsigned HOST_AW   = 16,
    parameter int unsigned MAX_BYTES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [63:0]        host_wdata,
    output logic [63:0]        host_rdata,
    output logic               host_rvalid,
    input  logic               busy_i,
    input  logic [63:0]        stat_i,
    output logic               launch_o,
    output cmd_t               cmd_o,
    output logic               stat_rd_o,
    output logic [31:0]        data_o
);
    localparam logic [3:0] MAXB = 4'(MAX_BYTES);

    win_idx_e    idx;
    logic        wr_acc, rd_acc;
    logic [31:0] data_q;
    logic        unused_addr;

    assign idx         = win_idx_e'(host_addr[4:3]);
    assign wr_acc      = host_req && host_we;
    assign rd_acc      = host_req && !host_we;
    assign unused_addr = ^{host_addr[HOST_AW-1:5], host_addr[2:0]};
    assign cmd_o       = decode_cmd(host_wdata);
    assign launch_o    = wr_acc && (idx == IDX_CTRL) && !busy_i && (cmd_o.nbytes <= MAXB);
    assign stat_rd_o   = rd_acc && (idx == IDX_STAT);
    assign data_o      = data_q;

    // Data register: keeps the upper half of each write to index 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (wr_acc && idx == IDX_DATA) begin
            data_q <= host_wdata[63:32];
        end
    end

    // Registered read mux; status reads as zero while an operation is outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= rd_acc;
            host_rdata  <= '0;
            if (rd_acc) begin
                unique case (idx)
                    IDX_STAT: host_rdata <= busy_i ? 64'd0 : stat_i;
                    IDX_DATA: host_rdata <= {data_q, 32'd0};
                    default:  host_rdata <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/icb_status.sv
// Status register: loaded on completion, cleared on launch and on host read.
// Assumes launch and completion never coincide (launch requires idle).
module icb_status
    import icb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        launch_i,
    input  logic        stat_rd_i,
    input  logic        done_i,
    input  logic        done_rd_i,
    input  logic        done_fail_i,
    input  logic [31:0] done_data_i,
    output logic [63:0] stat_o
);
    // Completion has priority; a dropped command never reaches here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_o <= '0;
        end else if (done_i) begin
            stat_o <= pack_status(done_rd_i, done_fail_i, done_data_i);
        end else if (launch_i || stat_rd_i) begin
            stat_o <= '0;
        end
    end
endmodule

// File: rtl/icb_ds_master.sv
// Downstream request/acknowledge master with a fixed acknowledge time limit.
// Assumes ds_ack is only meaningful while ds_req is high.
module icb_ds_master
    import icb_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        launch_i,
    input  cmd_t        cmd_i,
    input  logic [31:0] data_i,
    output logic        busy_o,
    output logic        ds_req,
    output logic        ds_we,
    output logic [31:0] ds_addr,
    output logic [3:0]  ds_size,
    output logic [31:0] ds_wdata,
    input  logic        ds_ack,
    input  logic [31:0] ds_rdata,
    input  logic        ds_err,
    output logic        done_o,
    output logic        done_rd_o,
    output logic        done_fail_o,
    output logic [31:0] done_data_o
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] wait_cnt;
    logic             expired;

    assign expired     = ds_req && !ds_ack && (wait_cnt == LAST);
    assign done_o      = ds_req && (ds_ack || expired);
    assign done_rd_o   = !ds_we;
    assign done_fail_o = !ds_ack || ds_err;
    assign done_data_o = ds_rdata;
    assign busy_o      = ds_req;

    // Request lifetime: rises on launch, falls on acknowledge or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ds_req <= 1'b0;
        end else if (launch_i) begin
            ds_req <= 1'b1;
        end else if (done_o) begin
            ds_req <= 1'b0;
        end
    end

    // Operation fields, captured once per launch and held during the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ds_we    <= 1'b0;
            ds_addr  <= '0;
            ds_size  <= '0;
            ds_wdata <= '0;
        end else if (launch_i) begin
            ds_we    <= !cmd_i.rd;
            ds_addr  <= cmd_i.addr;
            ds_size  <= cmd_i.nbytes;
            ds_wdata <= data_i;
        end
    end

    // Wait counter: cycles elapsed since the request rose.
    always_ff @(posedge clk) begin
        if (!rst_n || launch_i) begin
            wait_cnt <= '0;
        end else if (ds_req && !done_o) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/icb_bridge.sv
// Top of the indirect command/status bridge: host window to downstream master.
// Assumes a single host and one outstanding downstream operation at most.
module icb_bridge
    import icb_pkg::*;
#(
    parameter int unsigned HOST_AW     = 16,
    parameter int unsigned MAX_BYTES   = 8,
    parameter int unsigned TIMEOUT_CYC = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [63:0]        host_wdata,
    output logic [63:0]        host_rdata,
    output logic               host_rvalid,
    output logic               ds_req,
    output logic               ds_we,
    output logic [31:0]        ds_addr,
    output logic [3:0]         ds_size,
    output logic [31:0]        ds_wdata,
    input  logic               ds_ack,
    input  logic [31:0]        ds_rdata,
    input  logic               ds_err
);
    logic        busy, launch, stat_rd;
    logic        done, done_rd, done_fail;
    logic [31:0] done_data, data_q;
    logic [63:0] stat_q;
    cmd_t        cmd;

    icb_host_regs #(.HOST_AW(HOST_AW), .MAX_BYTES(MAX_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .busy_i(busy), .stat_i(stat_q), .launch_o(launch), .cmd_o(cmd),
        .stat_rd_o(stat_rd), .data_o(data_q)
    );

    icb_status u_stat (
        .clk(clk), .rst_n(rst_n), .launch_i(launch), .stat_rd_i(stat_rd),
        .done_i(done), .done_rd_i(done_rd), .done_fail_i(done_fail),
        .done_data_i(done_data), .stat_o(stat_q)
    );

    icb_ds_master #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ds (
        .clk(clk), .rst_n(rst_n), .launch_i(launch), .cmd_i(cmd), .data_i(data_q),
        .busy_o(busy), .ds_req(ds_req), .ds_we(ds_we), .ds_addr(ds_addr),
        .ds_size(ds_size), .ds_wdata(ds_wdata), .ds_ack(ds_ack),
        .ds_rdata(ds_rdata), .ds_err(ds_err), .done_o(done), .done_rd_o(done_rd),
        .done_fail_o(done_fail), .done_data_o(done_data)
    );
endmodule

// File: rtl/icb_checker.sv
// Protocol and status properties of the bridge, bound to the top module.
// Assumes it observes the internal status value and busy flag by name.
module icb_checker #(
    parameter int unsigned HOST_AW     = 16,
    parameter int unsigned MAX_BYTES   = 8,
    parameter int unsigned TIMEOUT_CYC = 256
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_req,
    input logic               host_we,
    input logic [HOST_AW-1:0] host_addr,
    input logic [63:0]        host_wdata,
    input logic [63:0]        host_rdata,
    input logic               host_rvalid,
    input logic               ds_req,
    input logic               ds_ack,
    input logic               ds_we,
    input logic [31:0]        ds_addr,
    input logic [3:0]         ds_size,
    input logic [63:0]        stat_q,
    input logic               busy
);
    localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1) + 1;
    localparam logic [3:0] MAXB = 4'(MAX_BYTES);

    logic [CW-1:0] req_run;

    // Length of the current unbroken request, counted independently of the design.
    always_ff @(posedge clk) begin
        if (!rst_n || !ds_req) req_run <= '0;
        else                   req_run <= req_run + 1'b1;
    end

    a_r13_rvalid_next: assert property (@(posedge clk) disable iff (!rst_n)
        host_req && !host_we |=> host_rvalid);

    a_r4_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ds_req && !ds_ack |=> $stable(ds_addr) && $stable(ds_size) && $stable(ds_we));

    a_r5_oversize_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        host_req && host_we && host_addr[4:3] == 2'd0 && !ds_req
        && host_wdata[59:56] > MAXB |=> !ds_req);

    a_r8_write_status: assert property (@(posedge clk) disable iff (!rst_n)
        ds_req && ds_ack && ds_we |=> stat_q == 64'h800);

    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        host_req && !host_we && host_addr[4:3] == 2'd2 && !busy |=> stat_q == 64'd0);

    a_r11_busy_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        host_req && !host_we && host_addr[4:3] == 2'd2 && busy |=> host_rdata == 64'd0);

    a_r12_request_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        req_run <= CW'(TIMEOUT_CYC));
endmodule

bind icb_bridge icb_checker #(
    .HOST_AW(HOST_AW), .MAX_BYTES(MAX_BYTES), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .ds_req(ds_req), .ds_ack(ds_ack), .ds_we(ds_we),
    .ds_addr(ds_addr), .ds_size(ds_size), .stat_q(stat_q), .busy(busy)
);

// File: tb/icb_bridge_tb_top.sv
`timescale 1ns/1ps
module icb_bridge_tb_top;
    localparam int unsigned HOST_AW = 16;
    localparam int unsigned TO_CYC  = 256;
    localparam logic [HOST_AW-1:0] A_CTRL = 16'h0000;
    localparam logic [HOST_AW-1:0] A_RSTR = 16'h0008;
    localparam logic [HOST_AW-1:0] A_STAT = 16'h0010;
    localparam logic [HOST_AW-1:0] A_DATA = 16'h0018;
    localparam logic [63:0] DONE = 64'h800;
    localparam logic [63:0] ONES = DONE | (64'hFFFF_FFFF << 26);

    typedef struct packed {
        logic        rd;
        logic [3:0]  size;
        logic [31:0] addr;
        logic [31:0] wval;
        logic [31:0] rresp;
        logic        err;
        logic [63:0] exp_stat;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{1'b1, 4'd4, 32'hD001_0060, 32'h0,         32'h1234_5678, 1'b0, DONE | (64'h1234_5678 << 26)},
        '{1'b0, 4'd1, 32'hE000_0004, 32'hA500_0000, 32'h0,         1'b0, DONE},
        '{1'b1, 4'd8, 32'hF000_0100, 32'h0,         32'h5555_AAAA, 1'b1, ONES},
        '{1'b0, 4'd4, 32'hC001_2024, 32'h0102_0304, 32'h0,         1'b1, DONE},
        '{1'b1, 4'd0, 32'h0000_0000, 32'h0,         32'hDEAD_BEEF, 1'b0, DONE | (64'hDEAD_BEEF << 26)}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               host_req = 1'b0, host_we = 1'b0;
    logic [HOST_AW-1:0] host_addr = '0;
    logic [63:0]        host_wdata = '0;
    logic [63:0]        host_rdata;
    logic               host_rvalid;
    logic               ds_req, ds_we;
    logic [31:0]        ds_addr, ds_wdata;
    logic [3:0]         ds_size;
    logic               ds_ack = 1'b0, ds_err = 1'b0;
    logic [31:0]        ds_rdata = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    icb_bridge #(.HOST_AW(HOST_AW), .TIMEOUT_CYC(TO_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .ds_req(ds_req), .ds_we(ds_we), .ds_addr(ds_addr),
        .ds_size(ds_size), .ds_wdata(ds_wdata), .ds_ack(ds_ack), .ds_rdata(ds_rdata),
        .ds_err(ds_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [HOST_AW-1:0] a, input logic [63:0] d);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_rd(input logic [HOST_AW-1:0] a, output logic [63:0] d);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        host_req = 1'b0;
        chk("R13 rvalid", 64'(host_rvalid), 64'd1);
        d = host_rdata;
    endtask

    task automatic run_cmd(input logic rd, input logic [3:0] sz, input logic [31:0] a);
        host_wr(A_CTRL, {4'h0, sz, 7'h0, rd, 16'h0, a});
    endtask

    task automatic respond(input logic [31:0] rdat, input logic err);
        @(negedge clk);
        ds_ack = 1'b1; ds_rdata = rdat; ds_err = err;
        @(negedge clk);
        ds_ack = 1'b0; ds_err = 1'b0;
    endtask

    initial begin
        repeat (TO_CYC * 40) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        chk("R4 reset ds_req", 64'(ds_req), 64'd0);
        host_rd(A_STAT, rv); chk("R9 reset status", rv, 64'd0);
        host_rd(A_DATA, rv); chk("R2 reset data", rv, 64'd0);

        // Vector table walk
        for (int i = 0; i < 5; i++) begin
            host_wr(A_DATA, {VEC[i].wval, 32'hFFFF_FFFF});
            run_cmd(VEC[i].rd, VEC[i].size, VEC[i].addr);
            chk("R4 req raised", 64'(ds_req), 64'd1);
            chk("R4 direction", 64'(ds_we), 64'(!VEC[i].rd));
            chk("R4 address", 64'(ds_addr), 64'(VEC[i].addr));
            chk("R4 size", 64'(ds_size), 64'(VEC[i].size));
            if (!VEC[i].rd) chk("R8 write data", 64'(ds_wdata), 64'(VEC[i].wval));
            respond(VEC[i].rresp, VEC[i].err);
            chk("R4 req dropped", 64'(ds_req), 64'd0);
            host_rd(A_STAT, rv);
            chk(VEC[i].rd ? (VEC[i].err ? "R7 read fail" : "R6 read ok") : "R8 write done",
                rv, VEC[i].exp_stat);
            host_rd(A_STAT, rv); chk("R9 cleared", rv, 64'd0);
        end

        // Aliasing and data register field
        host_wr(16'h0038, 64'hCAFE_F00D_1111_1111);
        host_rd(A_DATA, rv); chk("R1 R2 alias data", rv, 64'hCAFE_F00D_0000_0000);
        host_rd(16'h0070, rv); chk("R1 alias status", rv, 64'd0);
        host_rd(A_CTRL, rv); chk("R3 ctrl reads zero", rv, 64'd0);
        host_rd(A_RSTR, rv); chk("R3 reset reads zero", rv, 64'd0);

        // Writes to status/reset do nothing
        run_cmd(1'b1, 4'd2, 32'h10);
        respond(32'h0BAD_CAFE, 1'b0);
        host_wr(A_STAT, '1);
        host_wr(A_RSTR, '1);
        chk("R3 no request", 64'(ds_req), 64'd0);
        host_rd(A_STAT, rv); chk("R3 status kept", rv, DONE | (64'h0BAD_CAFE << 26));

        // Oversize command dropped, status unchanged
        run_cmd(1'b0, 4'd1, 32'h20);
        respond(32'h0, 1'b0);
        run_cmd(1'b1, 4'd9, 32'h30);
        chk("R5 no request", 64'(ds_req), 64'd0);
        host_rd(A_STAT, rv); chk("R5 status unchanged", rv, DONE);

        // Busy: status reads zero, control write ignored
        run_cmd(1'b1, 4'd4, 32'h0000_4444);
        host_rd(A_STAT, rv); chk("R11 busy status", rv, 64'd0);
        run_cmd(1'b0, 4'd1, 32'h0000_9999);
        chk("R10 addr kept", 64'(ds_addr), 64'h4444);
        chk("R10 dir kept", 64'(ds_we), 64'd0);
        respond(32'h7777_0000, 1'b0);
        host_rd(A_STAT, rv); chk("R10 original result", rv, DONE | (64'h7777_0000 << 26));

        // Time-out
        run_cmd(1'b1, 4'd4, 32'h0000_0ABC);
        repeat (TO_CYC - 1) @(negedge clk);
        chk("R12 still waiting", 64'(ds_req), 64'd1);
        @(negedge clk);
        chk("R12 request dropped", 64'(ds_req), 64'd0);
        host_rd(A_STAT, rv); chk("R12 failed read status", rv, ONES);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule